// File: doc/BRIEF.md
# SPI Serial Clock Divider with Linear and Power-of-Two Ratios

This block derives the serial clock of an SPI controller from its reference clock. It also marks, for every serial clock transition, whether the shift logic should put the next bit out (launch) or capture the incoming bit (sample). A single select bit sets how the ratio is formed. In linear mode, a 4-bit divider field and an 8-bit extension field are joined into a 12-bit value, and the ratio is that value plus one. In power-of-two mode, the 4-bit field is an exponent and the extension is not used.

The divider fields, the polarity and the phase are captured on every reference cycle in which `run_en` is low. They are frozen while `run_en` is high, so a serial word is never clocked with mixed settings. When `run_en` drops, the clock returns to its idle level and the half-period counter clears. The ratio computation and the shift register that consumes the strobes sit outside this block.

Top module: `spi_clkdiv`

## Requirements
- R1: With `gran_fine` = 1 the ratio N is the unsigned value {`ext_field`, `div_field`} (extension in the upper 8 bits) plus one, giving 1 to 4096.
- R2: With `gran_fine` = 0 the ratio N is 2 to the power `div_field` (1 to 32768), and `ext_field` has no effect on the waveform.
- R3: For N of 2 or more the serial clock period is N reference cycles: the active (non-idle) level lasts ceil(N/2) cycles and the idle level floor(N/2) cycles. N = 1 behaves like N = 2, so the clock toggles every reference cycle.
- R4: After `run_en` goes high, the first transition to the active level happens on the floor(N/2)-th rising reference edge, counting the first edge that samples `run_en` high (the first edge when N = 1).
- R5: `sclk` rests at the level of `cpol` when not running: 0 is idle low, 1 is idle high.
- R6: One cycle after `run_en` is sampled low, `sclk` is at its idle level and both strobes are low, whatever point of the period the clock had reached.
- R7: Changes to `gran_fine`, `div_field`, `ext_field`, `cpol` and `cpha` while `run_en` is high have no effect. Values present while `run_en` is low are used by the next run.
- R8: Each strobe is one reference cycle wide and is high in the first cycle in which `sclk` shows its new level. Exactly one strobe fires per `sclk` transition while running, and neither fires otherwise.
- R9: With `cpha` = 0, `sample_stb` marks transitions into the active level and `launch_stb` marks transitions back to idle. With `cpha` = 1 the two roles are swapped.
- R10: During and straight after reset, `sclk` is 0 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run the serial clock while high; idle and capture settings while low |
| gran_fine | input | 1 | 1 = linear ratio, 0 = power-of-two ratio |
| div_field | input | 4 | Low ratio bits (linear) or exponent (power-of-two) |
| ext_field | input | 8 | High ratio bits, linear mode only |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Selects which transition samples |
| sclk | output | 1 | Serial clock |
| launch_stb | output | 1 | One-cycle strobe: drive next bit |
| sample_stb | output | 1 | One-cycle strobe: capture bit |

## Verification
The waveform is measured as run lengths of `sclk`: the first idle stretch, then active, idle and active again. This is done for linear ratios of 1, 2, 7, 37 and 4096 and for power-of-two exponents of 0, 3, 5 and 15. Ratios 1 and 2 show the toggle-every-cycle case. Odd ratios show which level gets the extra cycle. The extremes show that no counter bit is dropped. The exponent 5 run is repeated with two different extension values, and the exponent 3 run uses a nonzero extension, which separates the two ratio modes. Both polarities and both phases are used, so each strobe is seen on each kind of transition. One run rewrites every setting halfway through, and the run lengths must stay unchanged.

// File: rtl/spi_clkdiv_pkg.sv
package spi_clkdiv_pkg;

  typedef enum logic {
    GRAN_POW2   = 1'b0,
    GRAN_LINEAR = 1'b1
  } gran_e;

  typedef struct packed {
    logic lead;   // idle -> active transition just happened
    logic trail;  // active -> idle transition just happened
  } sclk_edge_t;

endpackage

// File: rtl/spi_clkdiv_ratio.sv
module spi_clkdiv_ratio
  import spi_clkdiv_pkg::*;
#(
  parameter int DIV_W  = 4,
  parameter int EXT_W  = 8,
  parameter int HALF_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              gran_fine,
  input  logic [DIV_W-1:0]  div_field,
  input  logic [EXT_W-1:0]  ext_field,
  input  logic              cpol,
  input  logic              cpha,
  output logic [HALF_W-1:0] act_len,
  output logic [HALF_W-1:0] idle_len,
  output logic              cpol_q,
  output logic              cpha_q
);

  localparam int RATIO_W = HALF_W + 1;

  gran_e               gran;
  logic [RATIO_W-1:0]  ratio;
  logic [RATIO_W:0]    ratio_p1;
  logic [HALF_W-1:0]   act_len_d;
  logic [HALF_W-1:0]   idle_len_d;
  logic                cfg_load;

  assign gran     = gran_e'(gran_fine);
  assign cfg_load = ~run_en;

  always_comb begin
    if (gran == GRAN_LINEAR) begin
      ratio = RATIO_W'({ext_field, div_field}) + RATIO_W'(1);
    end else begin
      ratio = RATIO_W'(1) << div_field;
    end
    ratio_p1   = {1'b0, ratio} + (RATIO_W+1)'(1);
    act_len_d  = HALF_W'(ratio_p1 >> 1);
    if (ratio == RATIO_W'(1)) begin
      idle_len_d = HALF_W'(1);
    end else begin
      idle_len_d = HALF_W'(ratio >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_len  <= HALF_W'(1);
      idle_len <= HALF_W'(1);
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
    end else if (cfg_load) begin
      act_len  <= act_len_d;
      idle_len <= idle_len_d;
      cpol_q   <= cpol;
      cpha_q   <= cpha;
    end
  end

  // R7: captured settings stay frozen across consecutive running cycles
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en)) |-> ($stable(act_len) && $stable(idle_len)
                                   && $stable(cpol_q) && $stable(cpha_q)));

  // R3: neither half of the period may ever be empty
  a_r3_nonzero_halves: assert property (@(posedge clk) disable iff (!rst_n)
    (act_len != '0) && (idle_len != '0));

endmodule

// File: rtl/spi_clkdiv_core.sv
module spi_clkdiv_core
  import spi_clkdiv_pkg::*;
#(
  parameter int HALF_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [HALF_W-1:0] act_len,
  input  logic [HALF_W-1:0] idle_len,
  output logic              lvl_act,
  output sclk_edge_t        edges
);

  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              act_d;
  sclk_edge_t        edges_d;
  logic [HALF_W-1:0] half_len;
  logic              half_done;

  assign half_len  = lvl_act ? act_len : idle_len;
  assign half_done = (cnt_q == half_len - HALF_W'(1));

  always_comb begin
    cnt_d   = cnt_q;
    act_d   = lvl_act;
    edges_d = '0;
    if (!run_en) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (half_done) begin
      cnt_d         = '0;
      act_d         = ~lvl_act;
      edges_d.lead  = ~lvl_act;
      edges_d.trail = lvl_act;
    end else begin
      cnt_d = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lvl_act <= 1'b0;
      edges   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      lvl_act <= act_d;
      edges   <= edges_d;
    end
  end

  // R6: a stopped clock returns to idle with a cleared counter
  a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!lvl_act && cnt_q == '0 && edges == '0));

  // R3: the counter never runs past the length of the current half
  a_r3_cnt_in_half: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> (cnt_q < half_len));

  // R8: every reported edge coincides with a change of level
  a_r8_edge_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (edges.lead || edges.trail) |-> (lvl_act != $past(lvl_act)));

  // R8: a lead edge leaves the clock active, a trail edge leaves it idle
  a_r8_edge_direction: assert property (@(posedge clk) disable iff (!rst_n)
    (edges.lead |-> lvl_act) and (edges.trail |-> !lvl_act));

endmodule

// File: rtl/spi_clkdiv_strobe.sv
module spi_clkdiv_strobe
  import spi_clkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_act,
  input  sclk_edge_t edges,
  input  logic       cpol_q,
  input  logic       cpha_q,
  output logic       sclk,
  output logic       launch_stb,
  output logic       sample_stb
);

  always_comb begin
    sclk = lvl_act ^ cpol_q;
    if (cpha_q) begin
      launch_stb = edges.lead;
      sample_stb = edges.trail;
    end else begin
      launch_stb = edges.trail;
      sample_stb = edges.lead;
    end
  end

  // R8: never more than one strobe in a cycle
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({launch_stb, sample_stb}));

  // R5: while the clock is idle the output equals the captured polarity
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_act |-> (sclk == cpol_q));

endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv
  import spi_clkdiv_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             gran_fine,
  input  logic [DIV_W-1:0] div_field,
  input  logic [EXT_W-1:0] ext_field,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk,
  output logic             launch_stb,
  output logic             sample_stb
);

  localparam int FINE_W = DIV_W + EXT_W;
  localparam int POW_W  = (2 ** DIV_W) - 1;
  localparam int HALF_W = (FINE_W > POW_W) ? FINE_W : POW_W;

  logic [HALF_W-1:0] act_len;
  logic [HALF_W-1:0] idle_len;
  logic              cpol_q;
  logic              cpha_q;
  logic              lvl_act;
  sclk_edge_t        edges;

  spi_clkdiv_ratio #(
    .DIV_W  (DIV_W),
    .EXT_W  (EXT_W),
    .HALF_W (HALF_W)
  ) u_ratio (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .gran_fine (gran_fine),
    .div_field (div_field),
    .ext_field (ext_field),
    .cpol      (cpol),
    .cpha      (cpha),
    .act_len   (act_len),
    .idle_len  (idle_len),
    .cpol_q    (cpol_q),
    .cpha_q    (cpha_q)
  );

  spi_clkdiv_core #(
    .HALF_W (HALF_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .act_len  (act_len),
    .idle_len (idle_len),
    .lvl_act  (lvl_act),
    .edges    (edges)
  );

  spi_clkdiv_strobe u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_act    (lvl_act),
    .edges      (edges),
    .cpol_q     (cpol_q),
    .cpha_q     (cpha_q),
    .sclk       (sclk),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb)
  );

  // R8: a strobe while running always sits on a changed serial clock level
  a_r8_strobe_at_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en) && (launch_stb || sample_stb)) |-> (sclk != $past(sclk)));

  // R6: one cycle after a stop, no strobe is present
  a_r6_quiet_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!launch_stb && !sample_stb));

endmodule

// File: tb/spi_clkdiv_tb.sv
module spi_clkdiv_tb;

  logic       clk;
  logic       rst_n;
  logic       run_en;
  logic       gran_fine;
  logic [3:0] div_field;
  logic [7:0] ext_field;
  logic       cpol;
  logic       cpha;
  logic       sclk;
  logic       launch_stb;
  logic       sample_stb;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  spi_clkdiv u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .gran_fine  (gran_fine),
    .div_field  (div_field),
    .ext_field  (ext_field),
    .cpol       (cpol),
    .cpha       (cpha),
    .sclk       (sclk),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One directed scenario: configure while idle, run through four transitions,
  // measure the run lengths of sclk and the strobes, then stop.
  task automatic run_case(input string name, input bit g, input int dv, input int ex,
                          input bit pol, input bit pha, input bit disturb);
    int n, a_len, i_len, idx, len, guard, bad;
    int runs[4];
    bit prev, cur, lead, exp_l;
    string req;
    if (g) n = ex * 16 + dv + 1;
    else   n = 1 << dv;
    a_len = (n + 1) / 2;
    i_len = (n == 1) ? 1 : n / 2;
    req   = g ? "R1" : "R2";
    @(negedge clk);
    run_en = 1'b0; gran_fine = g; div_field = 4'(dv); ext_field = 8'(ex);
    cpol = pol; cpha = pha;
    repeat (3) @(negedge clk);
    // R5: idle level follows polarity
    chk(sclk == pol, {"R5 idle level ", name}, sclk, pol);
    run_en = 1'b1;
    idx = 0; len = 0; guard = 0; bad = 0; prev = pol;
    while (idx < 4 && guard < 4 * n + 20) begin
      @(negedge clk);
      guard++;
      cur = sclk;
      if (cur != prev) begin
        lead  = (cur != pol);
        exp_l = lead ? pha : !pha;
        if (launch_stb !== exp_l || sample_stb !== !exp_l) bad++;
        runs[idx] = len;
        idx++;
        len  = 1;
        prev = cur;
        if (disturb && idx == 1) begin
          // R7: rewrite every setting mid-run
          gran_fine = !g; div_field = 4'(dv ^ 5); ext_field = 8'(~ex);
          cpol = !pol; cpha = !pha;
        end
      end else begin
        if (launch_stb || sample_stb) bad++;
        len++;
      end
    end
    chk(idx == 4, {"R3 transitions seen ", name}, idx, 4);
    // R4: first idle stretch after start
    chk(runs[0] == i_len - 1, {"R4 start delay ", name}, runs[0], i_len - 1);
    // R3 with the ratio formed per R1 or R2
    chk(runs[1] == a_len, {req, "/R3 active half ", name}, runs[1], a_len);
    chk(runs[2] == i_len, {req, "/R3 idle half ", name},   runs[2], i_len);
    chk(runs[3] == a_len, {req, "/R3 second active ", name}, runs[3], a_len);
    // R8 and R9: strobe per transition with phase-dependent role
    chk(bad == 0, {"R8/R9 strobes ", name}, bad, 0);
    if (disturb) chk(runs[1] == a_len && runs[2] == i_len, {"R7 frozen settings ", name}, runs[2], i_len);
    // stop in the middle of a half, restore settings
    run_en = 1'b0; gran_fine = g; div_field = 4'(dv); ext_field = 8'(ex);
    cpol = pol; cpha = pha;
    @(negedge clk);
    // R6: idle and quiet one cycle after stop
    chk(sclk == pol, {"R6 stop level ", name}, sclk, pol);
    chk(!launch_stb && !sample_stb, {"R6 stop strobes ", name}, launch_stb + sample_stb, 0);
  endtask

  task automatic reset_case();
    rst_n = 1'b0; run_en = 1'b0; gran_fine = 1'b1; div_field = '0; ext_field = '0;
    cpol = 1'b0; cpha = 1'b0;
    repeat (2) @(negedge clk);
    // R10: outputs during reset
    chk(sclk == 1'b0 && !launch_stb && !sample_stb, "R10 in reset",
        sclk + launch_stb + sample_stb, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b0 && !launch_stb && !sample_stb, "R10 after reset",
        sclk + launch_stb + sample_stb, 0);
  endtask

  initial begin
    reset_case();
    run_case("lin N1",    1'b1, 0,  0,   1'b0, 1'b0, 1'b0);
    run_case("lin N2",    1'b1, 1,  0,   1'b1, 1'b0, 1'b0);
    run_case("lin N7",    1'b1, 6,  0,   1'b1, 1'b1, 1'b0);
    run_case("lin N37",   1'b1, 4,  2,   1'b0, 1'b1, 1'b1);
    run_case("lin N4096", 1'b1, 15, 255, 1'b0, 1'b0, 1'b0);
    run_case("pow e0",    1'b0, 0,  77,  1'b1, 1'b1, 1'b0);
    run_case("pow e3",    1'b0, 3,  171, 1'b0, 1'b1, 1'b0);
    run_case("pow e5 x0", 1'b0, 5,  0,   1'b0, 1'b0, 1'b0);
    run_case("pow e5 xF", 1'b0, 5,  255, 1'b0, 1'b0, 1'b0);
    run_case("pow e15",   1'b0, 15, 0,   1'b1, 1'b0, 1'b0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #1900000;
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule